// File: doc/BRIEF.md
# Light-Load and Fault Supervisor for a Resonant Synchronous Rectifier

This block decides, once per clock, whether the two secondary-side rectifier gate drivers may switch. It reads comparator flags and a per-cycle conduction time, all produced by analog front ends outside this block. It combines three kinds of information into one gate-enable. The first is a light-load tracker: it enters a power-saving state when the rectifiers conduct only briefly, cycle after cycle, and when the detect input stays high for a long burst-mode gap. The second is a frequency band chosen from the program-pin voltage. The third is a set of supervised faults.

The conduction time arrives as a count of clock ticks, together with a one-cycle strobe at the end of each conduction interval. The program-pin band is captured on the first clock after reset and then held, so the light-load threshold stays fixed while the block runs. Program-pin and output-short faults are filtered, then latched until reset. Over-voltage and over-temperature follow their conditions, and over-temperature clears with hysteresis.

Top module: `sr_light_load_supervisor`

## Requirements
- R1: While `rst_n` is low, `gate_en` is 0 and `fault` is 0.
- R2: `hf_mode` takes the value of `pin_hf` at the first rising clock edge after reset is released, and then holds it until the next reset, whatever `pin_hf` does.
- R3: A cycle counts as short when `cond_time` is strictly below the threshold: 375 ticks when `hf_mode` is 0 and 190 ticks when `hf_mode` is 1. A value equal to or above the threshold counts as long.
- R4: Seven short cycles in a row, with no light-load state in effect, put the block into the light-load state on the edge of the seventh strobe. From that point `gate_en` is 0.
- R5: From the light-load state, seven long cycles in a row return the block to normal gating on the edge of the seventh strobe.
- R6: A cycle of the opposite kind clears a run in progress, so the seven cycles must be consecutive strobes.
- R7: `det_high` held for 2400 consecutive clock edges puts the block into the light-load state. A shorter high interval has no effect.
- R8: `pin_lo` or `pin_hi` high for 200 consecutive edges sets `fault` bit 0. That bit stays set until reset, and a shorter interval does not set it.
- R9: `fb_short` high for 9000 consecutive edges sets `fault` bit 1. That bit stays set until reset, and a shorter interval does not set it.
- R10: `fault` bit 2 equals `vdd_ovp` as sampled at the previous clock edge.
- R11: `fault` bit 3 is set by `otp_hot`, is cleared only by `otp_cool` while `otp_hot` is low, and otherwise holds its value.
- R12: `gate_en` is 1 exactly when the band has been captured, the light-load state is not in effect and all `fault` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_done | input | 1 | One-cycle strobe at the end of a conduction interval |
| cond_time | input | 12 | Conduction time of that interval, in clock ticks |
| det_high | input | 1 | Drain detect comparator reads high (rectifier not conducting) |
| pin_hf | input | 1 | Program pin is in the high-frequency band |
| pin_lo | input | 1 | Program pin is below the shorted-pin level |
| pin_hi | input | 1 | Program pin is above the open-pin level |
| vdd_ovp | input | 1 | Supply over-voltage comparator |
| otp_hot | input | 1 | Die temperature above the upper trip |
| otp_cool | input | 1 | Die temperature below the lower trip |
| fb_short | input | 1 | Supply-minus-feedback voltage below the short level |
| gate_en | output | 1 | Gate drivers may switch |
| hf_mode | output | 1 | Captured frequency band, 1 = high |
| fault | output | 4 | Fault bits: 0 pin, 1 output short, 2 over-voltage, 3 over-temperature |

## Verification
The collision of interest is the seventh long cycle, which ends the light-load state, landing on the same edge where `vdd_ovp` first shows up in the fault register. The bench builds a light-load state, feeds six long cycles, then drives the seventh strobe and `vdd_ovp` together on one falling edge. It expects `gate_en` low with `fault` bit 2 set after that edge. Once the supply flag drops, `gate_en` must come back with no further cycles, which proves the light-load exit was not lost to the fault.

// File: rtl/sls_pkg.sv
package sls_pkg;
    localparam int FLT_W   = 4;
    localparam int FLT_PIN = 0;
    localparam int FLT_SCP = 1;
    localparam int FLT_OVP = 2;
    localparam int FLT_OTP = 3;

    typedef logic [FLT_W-1:0] fault_t;
endpackage

// File: rtl/sls_debounce.sv
module sls_debounce #(
    parameter int HOLD = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic latched
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hit;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.hit) begin
            if (cond) begin
                if (st_q.cnt == CW'(HOLD - 1)) begin
                    st_d.hit = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched = st_q.hit;

    // R8 / R9: a latch only rises after its condition was present
    a_r8_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hit) |-> $past(cond));
    // R8 / R9: once set, held until reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hit |=> st_q.hit);
endmodule

// File: rtl/sls_green_tracker.sv
module sls_green_tracker #(
    parameter int CT_W        = 12,
    parameter int LF_THR      = 375,
    parameter int HF_THR      = 190,
    parameter int RUN_LEN     = 7,
    parameter int BURST_TICKS = 2400
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hf_mode,
    input  logic            cyc_done,
    input  logic [CT_W-1:0] cond_time,
    input  logic            det_high,
    output logic            green
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam int BW = $clog2(BURST_TICKS + 1);
    localparam logic [CT_W-1:0] LF_T = CT_W'(LF_THR);
    localparam logic [CT_W-1:0] HF_T = CT_W'(HF_THR);

    typedef struct packed {
        logic          green;
        logic [RW-1:0] run;
        logic [BW-1:0] hi_cnt;
    } gt_t;

    gt_t st_d, st_q;
    logic short_cyc, qual;

    always_comb begin
        short_cyc = cond_time < (hf_mode ? HF_T : LF_T);
        qual      = st_q.green ? !short_cyc : short_cyc;
        st_d      = st_q;

        if (cyc_done) begin
            if (qual) begin
                if (st_q.run == RW'(RUN_LEN - 1)) begin
                    st_d.green = !st_q.green;
                    st_d.run   = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end

        if (det_high) begin
            if (st_q.hi_cnt == BW'(BURST_TICKS - 1)) begin
                st_d.hi_cnt = '0;
                if (!st_d.green) begin
                    st_d.green = 1'b1;
                    st_d.run   = '0;
                end
            end else begin
                st_d.hi_cnt = st_q.hi_cnt + 1'b1;
            end
        end else begin
            st_d.hi_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign green = st_q.green;

    // R4 / R7: entry needs a strobe or a detect-high interval
    a_r4_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.green) |-> ($past(cyc_done) || $past(det_high)));
    // R5: exit only on a conduction strobe
    a_r5_exit_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.green) |-> $past(cyc_done));
    // R6: the run counter never reaches the run length
    a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < RW'(RUN_LEN));
endmodule

// File: rtl/sls_fault_unit.sv
module sls_fault_unit
    import sls_pkg::*;
#(
    parameter int PIN_HOLD = 200,
    parameter int SCP_HOLD = 9000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_lo,
    input  logic   pin_hi,
    input  logic   fb_short,
    input  logic   vdd_ovp,
    input  logic   otp_hot,
    input  logic   otp_cool,
    output fault_t fault
);
    typedef struct packed {
        logic ovp;
        logic otp;
    } fl_t;

    fl_t  st_d, st_q;
    logic pin_flt, scp_flt;

    sls_debounce #(.HOLD(PIN_HOLD)) u_pin (
        .clk(clk), .rst_n(rst_n), .cond(pin_lo | pin_hi), .latched(pin_flt));

    sls_debounce #(.HOLD(SCP_HOLD)) u_scp (
        .clk(clk), .rst_n(rst_n), .cond(fb_short), .latched(scp_flt));

    always_comb begin
        st_d     = st_q;
        st_d.ovp = vdd_ovp;
        if (otp_hot)       st_d.otp = 1'b1;
        else if (otp_cool) st_d.otp = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        fault          = '0;
        fault[FLT_PIN] = pin_flt;
        fault[FLT_SCP] = scp_flt;
        fault[FLT_OVP] = st_q.ovp;
        fault[FLT_OTP] = st_q.otp;
    end

    // R11: hysteresis on the temperature flag
    a_r11_set_by_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.otp) |-> $past(otp_hot));
    a_r11_clear_by_cool: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.otp) |-> ($past(otp_cool) && !$past(otp_hot)));
endmodule

// File: rtl/sr_light_load_supervisor.sv
module sr_light_load_supervisor
    import sls_pkg::*;
#(
    parameter int CT_W        = 12,
    parameter int LF_THR      = 375,
    parameter int HF_THR      = 190,
    parameter int RUN_LEN     = 7,
    parameter int BURST_TICKS = 2400,
    parameter int PIN_HOLD    = 200,
    parameter int SCP_HOLD    = 9000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_done,
    input  logic [CT_W-1:0] cond_time,
    input  logic            det_high,
    input  logic            pin_hf,
    input  logic            pin_lo,
    input  logic            pin_hi,
    input  logic            vdd_ovp,
    input  logic            otp_hot,
    input  logic            otp_cool,
    input  logic            fb_short,
    output logic            gate_en,
    output logic            hf_mode,
    output logic [3:0]      fault
);
    typedef struct packed {
        logic taken;
        logic hf;
    } md_t;

    md_t    md_d, md_q;
    logic   green;
    fault_t flt;

    always_comb begin
        md_d = md_q;
        if (!md_q.taken) begin
            md_d.taken = 1'b1;
            md_d.hf    = pin_hf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    sls_green_tracker #(
        .CT_W(CT_W), .LF_THR(LF_THR), .HF_THR(HF_THR),
        .RUN_LEN(RUN_LEN), .BURST_TICKS(BURST_TICKS)
    ) u_green (
        .clk(clk), .rst_n(rst_n), .hf_mode(md_q.hf), .cyc_done(cyc_done),
        .cond_time(cond_time), .det_high(det_high), .green(green));

    sls_fault_unit #(.PIN_HOLD(PIN_HOLD), .SCP_HOLD(SCP_HOLD)) u_fault (
        .clk(clk), .rst_n(rst_n), .pin_lo(pin_lo), .pin_hi(pin_hi),
        .fb_short(fb_short), .vdd_ovp(vdd_ovp), .otp_hot(otp_hot),
        .otp_cool(otp_cool), .fault(flt));

    assign gate_en = md_q.taken & ~green & ~(|flt);
    assign hf_mode = md_q.hf;
    assign fault   = flt;

    // R2: the captured band never moves once taken
    a_r2_band_held: assert property (@(posedge clk) disable iff (!rst_n)
        md_q.taken |=> $stable(md_q.hf));
    // R10 / R12: gating is never allowed right after supply over-voltage
    a_r10_no_gate_after_ovp: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> !$past(vdd_ovp));
    // R12: no gating before the band is captured
    a_r12_gate_needs_band: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> $past(rst_n));
endmodule

// File: tb/sim_sr_light_load_supervisor.sv
module sim_sr_light_load_supervisor;
    localparam int CLK_NS   = 10;
    localparam int LF_T     = 375;
    localparam int HF_T     = 190;
    localparam int BURST    = 2400;
    localparam int PIN_DB   = 200;
    localparam int SCP_DB   = 9000;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_done = 1'b0;
    logic [11:0] cond_time = '0;
    logic        det_high = 1'b0;
    logic        pin_hf = 1'b0, pin_lo = 1'b0, pin_hi = 1'b0;
    logic        vdd_ovp = 1'b0, otp_hot = 1'b0, otp_cool = 1'b0, fb_short = 1'b0;
    logic        gate_en, hf_mode;
    logic [3:0]  fault;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #(CLK_NS/2) clk = ~clk;

    sr_light_load_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .cond_time(cond_time),
        .det_high(det_high), .pin_hf(pin_hf), .pin_lo(pin_lo), .pin_hi(pin_hi),
        .vdd_ovp(vdd_ovp), .otp_hot(otp_hot), .otp_cool(otp_cool),
        .fb_short(fb_short), .gate_en(gate_en), .hf_mode(hf_mode), .fault(fault));

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WATCHDOG);
            report();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int t);
        cyc_done = 1'b1; cond_time = 12'(t);
        @(negedge clk);
        cyc_done = 1'b0;
    endtask

    task automatic strobes(input int n, input int t);
        for (int i = 0; i < n; i++) strobe(t);
    endtask

    task automatic do_reset(input logic hf);
        @(negedge clk);
        rst_n = 1'b0; pin_hf = hf;
        cyc_done = 0; det_high = 0; pin_lo = 0; pin_hi = 0;
        vdd_ovp = 0; otp_hot = 0; otp_cool = 0; fb_short = 0;
        edges(3);
        check("R1 gate_en in reset", 32'(gate_en), 0);
        check("R1 fault in reset", 32'(fault), 0);
        rst_n = 1'b1;
        edges(1);
        check("R2 band captured", 32'(hf_mode), 32'(hf));
        check("R12 gating after capture", 32'(gate_en), 1);
        pin_hf = ~hf;
        edges(2);
        check("R2 band held after pin moves", 32'(hf_mode), 32'(hf));
    endtask

    task automatic t_lf_runs();
        do_reset(1'b0);
        strobes(6, LF_T - 1);
        check("R4 six short cycles keep gating", 32'(gate_en), 1);
        strobe(LF_T - 1);
        check("R4 R3 seventh short enters light load", 32'(gate_en), 0);
        strobes(6, LF_T);
        check("R5 six long cycles stay in light load", 32'(gate_en), 0);
        strobe(LF_T);
        check("R5 R3 seventh long at threshold exits", 32'(gate_en), 1);
        strobes(6, LF_T - 1); strobe(LF_T); strobes(6, LF_T - 1);
        check("R6 broken run does not enter", 32'(gate_en), 1);
        strobe(LF_T - 1);
        check("R6 fresh run of seven enters", 32'(gate_en), 0);
        strobes(3, 1000); strobe(10); strobes(6, 1000);
        check("R6 broken long run does not exit", 32'(gate_en), 0);
        strobe(1000);
        check("R5 consecutive long run exits", 32'(gate_en), 1);
    endtask

    task automatic t_hf_runs();
        do_reset(1'b1);
        strobes(7, HF_T);
        check("R3 HF threshold value is long", 32'(gate_en), 1);
        strobes(7, 300);
        check("R3 LF-short value is long in HF", 32'(gate_en), 1);
        strobes(7, HF_T - 1);
        check("R3 R4 HF short run enters", 32'(gate_en), 0);
        strobes(7, HF_T);
        check("R5 HF long run exits", 32'(gate_en), 1);
    endtask

    task automatic t_burst();
        do_reset(1'b0);
        det_high = 1'b1; edges(BURST - 1); det_high = 1'b0;
        edges(1);
        check("R7 short high interval ignored", 32'(gate_en), 1);
        det_high = 1'b1; edges(BURST); det_high = 1'b0;
        edges(1);
        check("R7 long high interval enters", 32'(gate_en), 0);
        strobes(7, 1000);
        check("R7 R5 exit after burst entry", 32'(gate_en), 1);
    endtask

    task automatic t_pin_fault();
        do_reset(1'b0);
        pin_lo = 1'b1; edges(PIN_DB - 1); pin_lo = 1'b0;
        edges(2);
        check("R8 short pin-low glitch ignored", 32'(fault), 0);
        pin_lo = 1'b1; edges(PIN_DB); pin_lo = 1'b0;
        check("R8 pin-low fault bit 0", 32'(fault), 32'h1);
        edges(20);
        check("R8 pin fault latched", 32'(fault), 32'h1);
        check("R12 gate off on pin fault", 32'(gate_en), 0);
        do_reset(1'b0);
        pin_hi = 1'b1; edges(PIN_DB); pin_hi = 1'b0;
        edges(3);
        check("R8 pin-high fault bit 0", 32'(fault), 32'h1);
    endtask

    task automatic t_scp();
        do_reset(1'b0);
        fb_short = 1'b1; edges(SCP_DB - 1); fb_short = 1'b0;
        edges(2);
        check("R9 short feedback dip ignored", 32'(fault), 0);
        fb_short = 1'b1; edges(SCP_DB); fb_short = 1'b0;
        edges(5);
        check("R9 output short latched bit 1", 32'(fault), 32'h2);
        check("R12 gate off on output short", 32'(gate_en), 0);
    endtask

    task automatic t_ovp_otp();
        do_reset(1'b0);
        vdd_ovp = 1'b1; edges(1);
        check("R10 ovp bit 2 set", 32'(fault), 32'h4);
        check("R12 gate off on ovp", 32'(gate_en), 0);
        vdd_ovp = 1'b0; edges(1);
        check("R10 ovp clears", 32'(fault), 0);
        otp_hot = 1'b1; edges(1); otp_hot = 1'b0;
        edges(3);
        check("R11 temp bit 3 held between trips", 32'(fault), 32'h8);
        otp_hot = 1'b1; otp_cool = 1'b1; edges(1);
        check("R11 hot wins over cool", 32'(fault), 32'h8);
        otp_hot = 1'b0; edges(1); otp_cool = 1'b0;
        check("R11 cool clears temp bit", 32'(fault), 0);
        check("R12 gating back after faults clear", 32'(gate_en), 1);
    endtask

    task automatic t_exit_meets_ovp();
        do_reset(1'b0);
        strobes(7, 50);
        strobes(6, 1000);
        vdd_ovp = 1'b1;
        strobe(1000);
        check("R10 ovp on exit edge", 32'(fault), 32'h4);
        check("R12 gate off on exit edge with ovp", 32'(gate_en), 0);
        vdd_ovp = 1'b0; edges(1);
        check("R5 exit kept across ovp", 32'(gate_en), 1);
    endtask

    initial begin
        t_lf_runs();
        t_hf_runs();
        t_burst();
        t_pin_fault();
        t_scp();
        t_ovp_otp();
        t_exit_meets_ovp();
        done = 1;
        report();
    end
endmodule